// File: doc/BRIEF.md
# Framebuffer Control/Status Registers with Frame Interrupt

This block is the byte-wide control and status register bank of a framebuffer controller. It answers the upper half (offsets 0x10 to 0x1F) of a 32-byte register window and returns zero for the lower half. One byte is a control register whose top bit enables the frame interrupt. Another byte is a status register. It reports a sticky pending flag together with fixed identification bits for the monitor type and the colour board. The remaining bytes are general storage that other logic uses for cursor limits and video control.

A frame-end pulse from the video timing logic sets the pending flag when the interrupt is enabled. The interrupt line is a registered copy of that flag. Software acknowledges the interrupt by writing any value to the status byte.

Reads are combinational from the address. Writes take effect at the rising clock edge on which the write enable is high.

Top module: `fbc_ctrl_status`

## Requirements
- R1: After reset the interrupt line is low, the control byte (offset 0x10) and every storage byte (0x12 to 0x1F) read 0x00, and status (0x11) reads 0x61.
- R2: A write to offset 0x10 stores the full byte, which reads back unchanged. Bit 7 of that byte is the interrupt enable.
- R3: A read of offset 0x11 returns the pending flag in bit 7, ORed with the constant 0x60 (monitor identification) and the constant 0x01 (colour board). Status therefore reads 0x61 when the flag is clear and 0xE1 when it is set.
- R4: A frame-end pulse sets the pending flag at the same clock edge only when control bit 7 is 1. With control bit 7 at 0, a frame-end pulse leaves the flag clear.
- R5: Any write to offset 0x11 clears the pending flag, whatever the data written. The data is never stored.
- R6: The interrupt output equals the pending flag delayed by one clock cycle.
- R7: When a frame-end pulse with the interrupt enabled and a status write fall in the same cycle, the flag ends up set.
- R8: Offsets 0x12 to 0x1F are fourteen independent byte registers that read back the last value written to them.
- R9: Offsets 0x00 to 0x0F read as 0x00. Writes to them change no register and do not clear the pending flag.
- R10: Once set, the pending flag stays set across further frame-end pulses and across clearing the enable bit, until a status write clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the addressed byte |
| regAddr | input | 5 | Byte offset within the 32-byte window |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for regAddr (combinational) |
| frameEnd | input | 1 | One-cycle pulse at the end of each frame |
| irq | output | 1 | Level interrupt, registered copy of the pending flag |

## Verification
Two events can meet in one cycle: the frame-end set of the pending flag and the software acknowledge through a status write. The bench drives both on the same clock edge, once with the flag already set and once with it clear. It then reads status and expects 0xE1, and it expects the interrupt line to be high one cycle later, because the set must win. A status write alone, with several data patterns, must return status to 0x61.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  parameter int unsigned WIN_ADDR_W  = 5;
  parameter int unsigned DATA_W      = 8;
  parameter int unsigned SLOT_W      = WIN_ADDR_W - 1;
  parameter int unsigned NUM_SLOTS   = 1 << SLOT_W;
  parameter int unsigned CTRL_SLOT   = 0;
  parameter int unsigned STAT_SLOT   = 1;
  parameter int unsigned FIRST_STORE = 2;
  parameter int unsigned IEN_BIT     = 7;
  parameter int unsigned PEND_BIT    = 7;
  parameter logic [DATA_W-1:0] STAT_ID = 8'h61;
  parameter logic [WIN_ADDR_W-1:0] STAT_ADDR = WIN_ADDR_W'(NUM_SLOTS + STAT_SLOT);

  typedef struct packed {
    logic              ctrlWr;
    logic              statClr;
    logic              storeWr;
    logic [SLOT_W-1:0] slot;
    logic              frameSet;
  } fbcStrobes_t;
endpackage

// File: rtl/fbc_decode.sv
module fbc_decode
  import fbc_pkg::*;
(
  input  logic                  wrEn,
  input  logic [WIN_ADDR_W-1:0] regAddr,
  input  logic                  frameEnd,
  input  logic                  intEnable,
  output fbcStrobes_t           strobes
);
  logic              inWindow;
  logic [SLOT_W-1:0] slot;

  assign inWindow = regAddr[WIN_ADDR_W-1];
  assign slot     = regAddr[SLOT_W-1:0];

  always_comb begin
    strobes          = '0;
    strobes.slot     = slot;
    strobes.frameSet = frameEnd & intEnable;
    if (wrEn && inWindow) begin
      if (slot == SLOT_W'(CTRL_SLOT))       strobes.ctrlWr  = 1'b1;
      else if (slot == SLOT_W'(STAT_SLOT))  strobes.statClr = 1'b1;
      else                                  strobes.storeWr = 1'b1;
    end
  end
endmodule

// File: rtl/fbc_regs.sv
module fbc_regs
  import fbc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  fbcStrobes_t           strobes,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [WIN_ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0]     rdData,
  output logic                  intEnable,
  output logic                  pendFlag,
  output logic                  irqOut
);
  logic [DATA_W-1:0] ctrlQ;
  logic              pendQ;
  logic              irqQ;
  logic [DATA_W-1:0] storeQ [NUM_SLOTS];
  logic [DATA_W-1:0] statVal;
  logic [SLOT_W-1:0] rdSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ctrlQ <= '0;
    else if (strobes.ctrlWr) ctrlQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pendQ <= 1'b0;
    else if (strobes.frameSet) pendQ <= 1'b1;
    else if (strobes.statClr)  pendQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= pendQ;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    if (g >= FIRST_STORE) begin : gStore
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          storeQ[g] <= '0;
        else if (strobes.storeWr && strobes.slot == SLOT_W'(g))
          storeQ[g] <= wrData;
      end
    end else begin : gNone
      assign storeQ[g] = '0;
    end
  end

  assign statVal = STAT_ID | (DATA_W'(pendQ) << PEND_BIT);
  assign rdSlot  = regAddr[SLOT_W-1:0];

  always_comb begin
    rdData = '0;
    if (regAddr[WIN_ADDR_W-1]) begin
      if (rdSlot == SLOT_W'(CTRL_SLOT))      rdData = ctrlQ;
      else if (rdSlot == SLOT_W'(STAT_SLOT)) rdData = statVal;
      else                                   rdData = storeQ[rdSlot];
    end
  end

  assign intEnable = ctrlQ[IEN_BIT];
  assign pendFlag  = pendQ;
  assign irqOut    = irqQ;
endmodule

// File: rtl/fbc_ctrl_status.sv
module fbc_ctrl_status
  import fbc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [WIN_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  input  logic                  frameEnd,
  output logic                  irq
);
  fbcStrobes_t strobes;
  logic        intEnable;
  logic        pendFlag;

  fbc_decode uDecode (
    .wrEn      (wrEn),
    .regAddr   (regAddr),
    .frameEnd  (frameEnd),
    .intEnable (intEnable),
    .strobes   (strobes)
  );

  fbc_regs uRegs (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (wrData),
    .regAddr   (regAddr),
    .rdData    (rdData),
    .intEnable (intEnable),
    .pendFlag  (pendFlag),
    .irqOut    (irq)
  );
endmodule

// File: rtl/fbc_checker.sv
module fbc_checker
  import fbc_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [WIN_ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0]     rdData,
  input logic                  frameEnd,
  input logic                  irq,
  input logic                  intEnable,
  input logic                  pendFlag
);
  a_r6_irq_lags_pending: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irq == $past(pendFlag));

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && intEnable) |=> pendFlag);

  a_r5_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == STAT_ADDR && !(frameEnd && intEnable)) |=> !pendFlag);

  a_r4_rise_needs_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendFlag) |-> $past(frameEnd && intEnable));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (pendFlag && !(wrEn && regAddr == STAT_ADDR)) |=> pendFlag);

  a_r3_status_id: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == STAT_ADDR) |-> (rdData[PEND_BIT-1:0] == STAT_ID[PEND_BIT-1:0]
                                && rdData[PEND_BIT] == pendFlag));

  a_r9_low_half_zero: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr[WIN_ADDR_W-1] |-> rdData == '0);
endmodule

bind fbc_ctrl_status fbc_checker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .regAddr   (regAddr),
  .rdData    (rdData),
  .frameEnd  (frameEnd),
  .irq       (irq),
  .intEnable (intEnable),
  .pendFlag  (pendFlag)
);

// File: tb/tb_fbc_ctrl_status.sv
module tb_fbc_ctrl_status;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       frameEnd = 1'b0;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fbc_ctrl_status dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .frameEnd(frameEnd), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic frame();
    @(negedge clk);
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
  endtask

  task automatic tReset();
    logic [7:0] v;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(5'h10, v); chk("R1 ctrl", v, 8'h00);
    rd(5'h11, v); chk("R1 status", v, 8'h61);
    for (int i = 5'h12; i <= 5'h1F; i++) begin
      rd(5'(i), v); chk("R1 store", v, 8'h00);
    end
  endtask

  task automatic tCtrl();
    logic [7:0] v;
    wr(5'h10, 8'h5A); rd(5'h10, v); chk("R2 ctrl readback", v, 8'h5A);
    wr(5'h10, 8'h80); rd(5'h10, v); chk("R2 ctrl enable", v, 8'h80);
    wr(5'h10, 8'h00);
  endtask

  task automatic tFrameDisabled();
    logic [7:0] v;
    wr(5'h10, 8'h7F);
    frame();
    #1 chk("R4 disabled irq", {7'd0, irq}, 8'h00);
    rd(5'h11, v); chk("R4 disabled status", v, 8'h61);
    @(negedge clk); chk("R4 disabled irq later", {7'd0, irq}, 8'h00);
  endtask

  task automatic tFrameEnabled();
    logic [7:0] v;
    wr(5'h10, 8'h80);
    @(negedge clk);
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    regAddr = 5'h11;
    #1 chk("R3 status pending", rdData, 8'hE1);
    chk("R6 irq not yet", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R6 irq high", {7'd0, irq}, 8'h01);
    // status write clears; irq falls one cycle later
    wrEn = 1'b1; regAddr = 5'h11; wrData = 8'h80;
    @(negedge clk);
    wrEn = 1'b0;
    #1 chk("R5 cleared", rdData, 8'h61);
    chk("R6 irq still high", {7'd0, irq}, 8'h01);
    @(negedge clk);
    chk("R6 irq low", {7'd0, irq}, 8'h00);
    rd(5'h10, v); chk("R5 ctrl untouched", v, 8'h80);
  endtask

  task automatic tClearData();
    logic [7:0] v;
    logic [7:0] pats [3] = '{8'h00, 8'hFF, 8'h7E};
    wr(5'h10, 8'h80);
    foreach (pats[i]) begin
      frame();
      rd(5'h11, v); chk("R4 set", v, 8'hE1);
      wr(5'h11, pats[i]);
      rd(5'h11, v); chk("R5 clear any data", v, 8'h61);
    end
    wr(5'h11, 8'hFF);
    rd(5'h11, v); chk("R5 clear when idle", v, 8'h61);
  endtask

  task automatic tCollision();
    logic [7:0] v;
    wr(5'h10, 8'h80);
    for (int k = 0; k < 2; k++) begin
      if (k == 1) frame();
      @(negedge clk);
      frameEnd = 1'b1; wrEn = 1'b1; regAddr = 5'h11; wrData = 8'hFF;
      @(negedge clk);
      frameEnd = 1'b0; wrEn = 1'b0;
      #1 chk("R7 set wins status", rdData, 8'hE1);
      @(negedge clk);
      chk("R7 irq after collision", {7'd0, irq}, 8'h01);
      wr(5'h11, 8'h00);
      rd(5'h11, v); chk("R7 cleanup", v, 8'h61);
    end
  endtask

  task automatic tSticky();
    logic [7:0] v;
    wr(5'h10, 8'h80);
    frame();
    frame();
    rd(5'h11, v); chk("R10 two frames", v, 8'hE1);
    wr(5'h10, 8'h00);
    frame();
    rd(5'h11, v); chk("R10 after disable", v, 8'hE1);
    chk("R10 irq held", {7'd0, irq}, 8'h01);
    wr(5'h11, 8'h00);
    rd(5'h11, v); chk("R10 final clear", v, 8'h61);
  endtask

  task automatic tStorage();
    logic [7:0] v;
    for (int i = 5'h12; i <= 5'h1F; i++) wr(5'(i), 8'(i) ^ 8'hA5);
    for (int i = 5'h12; i <= 5'h1F; i++) begin
      rd(5'(i), v); chk("R8 store", v, 8'(i) ^ 8'hA5);
    end
    rd(5'h10, v); chk("R8 ctrl isolated", v, 8'h00);
    rd(5'h11, v); chk("R8 status isolated", v, 8'h61);
  endtask

  task automatic tUnmapped();
    logic [7:0] v;
    wr(5'h10, 8'h80);
    frame();
    for (int i = 0; i < 16; i++) wr(5'(i), 8'hFF);
    for (int i = 0; i < 16; i++) begin
      rd(5'(i), v); chk("R9 low half zero", v, 8'h00);
    end
    rd(5'h11, v); chk("R9 pending kept", v, 8'hE1);
    rd(5'h10, v); chk("R9 ctrl kept", v, 8'h80);
    rd(5'h12, v); chk("R9 store kept", v, 8'h12 ^ 8'hA5);
    rd(5'h1F, v); chk("R9 store kept", v, 8'h1F ^ 8'hA5);
    wr(5'h11, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tCtrl();
    tFrameDisabled();
    tFrameEnabled();
    tClearData();
    tCollision();
    tSticky();
    tStorage();
    tUnmapped();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule